// File: doc/BRIEF.md
# Stop Mode Recovery Controller

This block puts a small processor core into a low-power stop state and brings it back out. When the core issues a stop request while running, the block drives both system clock enables low. The main clock enable and the divided clock enable stay low until recovery is complete. While the block is stopped, its recovery counter is held at zero.

An interrupt or a break request ends the stop state and starts recovery. During recovery the counter advances on a free-running oscillator tick. When the counter reaches its terminal count, the block restores the clock enables and marks the return to running with a one-cycle core-run pulse.

A configuration input selects the recovery length: a long delay or a short delay. The block samples this input when recovery starts. A break that wakes the core sets a sticky status flag, and software clears that flag with a strobe.

Top module: `stop_recovery_ctrl`

## Requirements
- R1: After reset the block is running: `sys_clk_en` and `div_clk_en` are 1, `core_run` is 0 and `brk_flag` is 0.
- R2: A `stop_req` sampled high while running drives `sys_clk_en` and `div_clk_en` low from the next cycle.
- R3: An `irq` or `brk` sampled high while stopped starts recovery on the next cycle. With `short_rec` at 0, the clock enables return high after exactly LONG_CYCLES `osc_tick` pulses (default 4096) have been counted in recovery.
- R4: With `short_rec` at 1 when recovery starts, the delay is SHORT_CYCLES ticks (default 2048).
- R5: `short_rec` is sampled in the cycle that recovery starts. Changing it during recovery does not alter the current delay.
- R6: The counter is held at zero while stopped. Ticks that arrive before the wake event do not shorten the recovery.
- R7: A `brk` sampled while stopped, or in the same cycle as an accepted `stop_req`, sets `brk_flag`. An `irq` wake-up leaves `brk_flag` unchanged.
- R8: `brk_flag` stays set until a `flag_clr` strobe clears it. If a clear and a set occur in the same cycle, the flag is set.
- R9: `core_run` is high for exactly one cycle, which is the first cycle in which the clock enables are back high.
- R10: A wake request in the same cycle as an accepted `stop_req` is held, and recovery starts one cycle after stop entry.
- R11: `stop_req` is ignored during recovery. `irq` and `brk` have no effect while running, apart from the break flag rule in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Free-running divided-oscillator tick that advances recovery |
| stop_req | input | 1 | Stop command from the core |
| irq | input | 1 | Interrupt wake request |
| brk | input | 1 | Break wake request |
| short_rec | input | 1 | 1 selects the short recovery delay |
| flag_clr | input | 1 | Strobe that clears the break status flag |
| sys_clk_en | output | 1 | Main clock enable, low while stopped or recovering |
| div_clk_en | output | 1 | Divided clock enable, low while stopped or recovering |
| core_run | output | 1 | One-cycle pulse when recovery completes |
| brk_flag | output | 1 | Sticky break-during-stop status |

## Verification
Every output is registered or decoded from registered state, so each result appears one clock edge after the input that causes it. The clock enables fall one edge after `stop_req`, recovery starts one edge after the wake request, and `core_run` rises on the edge that counts the final tick. The bench drives inputs just after a rising edge and samples at the falling edge. It compares a behavioural model against all four outputs on every cycle. Directed measurements also count the edges from the wake request to `core_run`: LONG_CYCLES+1 for a normal wake, and one more when the wake is held from stop entry.

// File: rtl/stop_recovery_ctrl.sv
module stop_recovery_ctrl #(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic stop_req,
  input  logic irq,
  input  logic brk,
  input  logic short_rec,
  input  logic flag_clr,
  output logic sys_clk_en,
  output logic div_clk_en,
  output logic core_run,
  output logic brk_flag
);
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_STOP = 2'd1, S_REC = 2'd2} mode_t;

  mode_t         state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          pend;

  wire wake     = irq | brk;
  wire enter    = (state == S_RUN) && stop_req;
  wire start    = (state == S_STOP) && (wake || pend);
  wire done     = (state == S_REC) && osc_tick && (cnt == last);
  wire brk_set  = brk && ((state == S_STOP) || enter);

  assign sys_clk_en = (state == S_RUN);
  assign div_clk_en = (state == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN;
      pend  <= 1'b0;
    end else begin
      case (state)
        S_RUN: if (stop_req) begin
          state <= S_STOP;
          pend  <= wake;
        end
        S_STOP: if (start) begin
          state <= S_REC;
          pend  <= 1'b0;
        end
        S_REC: if (done) state <= S_RUN;
        default: state <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      last <= LONG_LAST;
    end else if (start) begin
      cnt  <= '0;
      last <= short_rec ? SHORT_LAST : LONG_LAST;
    end else if (state != S_REC || done) begin
      cnt <= '0;
    end else if (osc_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_run <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      core_run <= done;
      if (brk_set)       brk_flag <= 1'b1;
      else if (flag_clr) brk_flag <= 1'b0;
    end
  end
endmodule

module stop_recovery_chk #(
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_req,
  input logic          irq,
  input logic          brk,
  input logic          flag_clr,
  input logic          sys_clk_en,
  input logic          core_run,
  input logic          brk_flag,
  input logic [1:0]    st,
  input logic [CW-1:0] cnt
);
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && stop_req) |=> !sys_clk_en); // R2
  AST_WAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && (irq || brk)) |=> (st == 2'd2)); // R3
  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2) |-> (cnt == '0)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !flag_clr) |=> brk_flag); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !brk) |=> !brk_flag); // R8
  AST_RUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> !core_run); // R9
  AST_RUN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> sys_clk_en); // R9
  AST_REC_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && stop_req) |=> (st != 2'd1)); // R11
endmodule

bind stop_recovery_ctrl stop_recovery_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq(irq), .brk(brk),
  .flag_clr(flag_clr), .sys_clk_en(sys_clk_en), .core_run(core_run),
  .brk_flag(brk_flag), .st(state), .cnt(cnt)
);

// File: tb/tb_stop_recovery_ctrl.sv
module tb_stop_recovery_ctrl;
  localparam int LONG  = 4096;
  localparam int SHORT = 2048;

  logic clk = 0, rst_n = 0;
  logic osc_tick = 1, stop_req = 0, irq = 0, brk = 0, short_rec = 0, flag_clr = 0;
  logic sys_clk_en, div_clk_en, core_run, brk_flag;

  int checks = 0, errors = 0;
  int tick_mode = 0;
  int tcnt = 0;

  stop_recovery_ctrl #(.LONG_CYCLES(LONG), .SHORT_CYCLES(SHORT)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .stop_req(stop_req),
    .irq(irq), .brk(brk), .short_rec(short_rec), .flag_clr(flag_clr),
    .sys_clk_en(sys_clk_en), .div_clk_en(div_clk_en),
    .core_run(core_run), .brk_flag(brk_flag)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    tcnt++;
    osc_tick = (tick_mode == 0) || tcnt[0];
  end

  // behavioural reference: mode 0 run, 1 stopped, 2 recovering
  int m_mode = 0, m_cnt = 0, m_lim = LONG;
  bit m_pend = 0, m_flag = 0, m_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_lim = LONG; m_pend = 0; m_flag = 0; m_run = 0;
    end else begin
      bit w;
      w = irq || brk;
      if (brk && (m_mode == 1 || (m_mode == 0 && stop_req))) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_run = 0;
      if (m_mode == 0) begin
        if (stop_req) begin m_mode = 1; m_pend = w; end
      end else if (m_mode == 1) begin
        if (w || m_pend) begin
          m_mode = 2; m_cnt = 0; m_pend = 0;
          m_lim = short_rec ? SHORT : LONG;
        end
      end else if (osc_tick) begin
        if (m_cnt == m_lim - 1) begin m_mode = 0; m_cnt = 0; m_run = 1; end
        else m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(sys_clk_en == (m_mode == 0), "R2/R3 sys_clk_en", sys_clk_en, m_mode == 0);
    chk(div_clk_en == (m_mode == 0), "R2/R3 div_clk_en", div_clk_en, m_mode == 0);
    chk(core_run == m_run, "R9 core_run", core_run, m_run);
    chk(brk_flag == m_flag, "R7/R8 brk_flag", brk_flag, m_flag);
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic go_stop();
    step(); stop_req = 1;
    step(); stop_req = 0;
  endtask

  // drive wake (optionally with stop_req) and count edges until core_run
  task automatic wake_measure(input bit use_brk, input bit with_stop, output int n);
    step();
    if (use_brk) brk = 1; else irq = 1;
    if (with_stop) stop_req = 1;
    n = 0;
    forever begin
      @(posedge clk); #2;
      irq = 0; brk = 0; stop_req = 0;
      n++;
      @(negedge clk);
      if (core_run || n > 20000) break;
    end
  endtask

  task automatic run_tests();
    int n;
    repeat (3) step();
    @(negedge clk);
    chk(sys_clk_en && div_clk_en, "R1 enables", sys_clk_en, 1);
    chk(!core_run, "R1 core_run", core_run, 0);
    chk(!brk_flag, "R1 brk_flag", brk_flag, 0);
    rst_n = 1;

    // R11: irq while running has no effect
    step(); irq = 1; step(); irq = 0;
    @(negedge clk); chk(sys_clk_en, "R11 irq in run", sys_clk_en, 1);

    // R2, R6, R3: long recovery after ticks during stop
    go_stop();
    @(negedge clk); chk(!sys_clk_en, "R2 stop gates", sys_clk_en, 0);
    repeat (50) step();
    wake_measure(0, 0, n);
    chk(n == LONG + 1, "R3/R6 long delay", n, LONG + 1);
    chk(!brk_flag, "R7 irq leaves flag", brk_flag, 0);
    step(); @(negedge clk); chk(!core_run, "R9 single pulse", core_run, 0);

    // R4, R7: short recovery by break
    short_rec = 1;
    go_stop();
    wake_measure(1, 0, n);
    chk(n == SHORT + 1, "R4 short delay", n, SHORT + 1);
    chk(brk_flag, "R7 brk sets flag", brk_flag, 1);
    repeat (5) step();
    @(negedge clk); chk(brk_flag, "R8 sticky", brk_flag, 1);
    step(); flag_clr = 1; step(); flag_clr = 0;
    @(negedge clk); chk(!brk_flag, "R8 cleared", brk_flag, 0);

    // R5: change short_rec during recovery
    short_rec = 0;
    go_stop();
    fork
      wake_measure(0, 0, n);
      begin repeat (10) step(); short_rec = 1; end
    join
    chk(n == LONG + 1, "R5 sampled at start", n, LONG + 1);

    // R10, R7: wake with stop entry (short), break held
    wake_measure(1, 1, n);
    chk(n == SHORT + 2, "R10 held wake", n, SHORT + 2);
    chk(brk_flag, "R7 brk at entry", brk_flag, 1);

    // R8: clear and set in the same cycle
    go_stop();
    brk = 1; flag_clr = 1;
    step(); brk = 0; flag_clr = 0;
    @(negedge clk); chk(brk_flag, "R8 set wins", brk_flag, 1);
    // R11: stop_req during recovery ignored
    repeat (20) step();
    stop_req = 1; step(); stop_req = 0;
    @(negedge clk); chk(!sys_clk_en, "R11 still recovering", sys_clk_en, 0);
    while (!core_run) @(negedge clk);
    repeat (5) step();
    @(negedge clk); chk(sys_clk_en, "R11 ran after recovery", sys_clk_en, 1);

    // slower oscillator ticks: model comparison covers timing
    tick_mode = 1;
    go_stop();
    wake_measure(0, 0, n);
    chk(n > SHORT * 2 - 2 && n < SHORT * 2 + 4, "R4 slow ticks", n, SHORT * 2);
    repeat (10) step();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule